// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block turns read and write requests from a 16-bit processor core into external bus cycles on a shared address/data bus. Each request carries a 20-bit address, a memory-or-I/O flag, a byte-or-word flag and, for writes, 16 bits of write data. The cycle runs through four phases. The address is presented with a latch strobe first. Then comes the data phase with the read or write strobe active. The phase after that can be stretched with wait states while the target holds its ready input low. A final recovery phase closes the cycle. During each cycle the controller also drives a bus status code, the byte-high enable and the direction and enable controls for external data transceivers.

A second master can ask for the bus with a hold request. The controller grants it only between cycles. While the grant is active, the controller releases every bus output. The core sees a one-cycle accept pulse when its request is taken. It sees a one-cycle completion pulse, together with captured read data, in the last phase of the cycle.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While and just after reset, the latch strobe is 0, rd_n, wr_n, hi_byte_n and xcvr_en_n are 1, hold_ack is 0, ad_oe is 0, ctl_oe is 1, and cyc_stat is passive (3'b111).
- R2: A request is accepted (req_ready=1) only when the controller is idle or in the last phase of a cycle, and only when hold_req is 0. An accept from the last phase starts the next cycle's address phase on the very next clock.
- R3: In the address phase (the first clock after acceptance), addr_latch=1, ad_oe=1, and ad_o carries the address. For an I/O access, bits 19:16 of ad_o are forced to 0.
- R4: cyc_stat is 3'b001 for I/O read, 3'b010 for I/O write, 3'b101 for memory read and 3'b110 for memory write. It holds this value from the address phase through the data and wait phases, and is 3'b111 in the last phase and when idle.
- R5: A read keeps ad_oe=0, rd_n=0 and wr_n=1 in the data, extend and wait phases. rd_n and wr_n are never both 0.
- R6: A write puts the write data on ad_o[15:0], with upper bits 0 and ad_oe=1, and drives wr_n=0 in the data, extend and wait phases.
- R7: A cycle lasts at least four clocks: address, data, extend, last. Each clock in which bus_ready is sampled low at the end of the extend or a wait phase adds exactly one wait clock. rsp_valid is 1 only in the last phase.
- R8: Read data is captured from ad_i on the clock edge that ends the extend or wait phase with bus_ready high. It appears on rsp_rdata while rsp_valid pulses for one clock.
- R9: dir_tx is 1 for writes and 0 for reads, and is already valid in the address phase. xcvr_en_n is 0 only in the data, extend and wait phases.
- R10: hold_ack rises one clock after hold_req is sampled high while idle or in the last phase, and never in the middle of a cycle. While hold_ack=1, ad_oe=0 and ctl_oe=0, and no request is accepted. hold_req wins over a simultaneous request.
- R11: hold_ack falls on the first clock edge at which hold_req is sampled low.
- R12: hi_byte_n is 0 for a word access. For a byte access it is 0 at an odd address and 1 at an even address, and it holds that value from the address phase through the last phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 20 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted this clock |
| rsp_valid | output | 1 | Cycle completes (last phase) |
| rsp_rdata | output | 16 | Captured read data |
| ad_o | output | 20 | Multiplexed address/data bus, driven value |
| ad_oe | output | 1 | Drive enable for ad_o |
| ad_i | input | 16 | Multiplexed bus, sampled value |
| addr_latch | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cyc_stat | output | 3 | Bus cycle status code |
| hi_byte_n | output | 1 | Upper byte lane enable, active low |
| xcvr_en_n | output | 1 | Transceiver enable, active low |
| dir_tx | output | 1 | Transceiver direction, 1 = toward bus |
| ctl_oe | output | 1 | Drive enable for control outputs |
| bus_ready | input | 1 | Target ready; low inserts wait states |
| hold_req | input | 1 | Other master requests the bus |
| hold_ack | output | 1 | Bus granted to other master |

## Verification
A wrong phase in the sequencer shows up on the strobes within one clock. A skipped or repeated phase moves rsp_valid away from its fixed position. It also lets rd_n, wr_n or xcvr_en_n stay active in the last phase, or lets the latch strobe reappear. A lost wait-state decision shows in the same clock as a missing or extra wait clock. A wrong capture edge shows as stale data on rsp_rdata during the completion pulse. A wrong hold decision shows one clock later, as hold_ack rising mid-cycle or as ad_oe and ctl_oe still driven during the grant.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_DATA, PH_EXT, PH_WAIT, PH_LAST, PH_HOLD
  } phase_e;

  localparam logic [2:0] STAT_IDLE = 3'b111;

  function automatic logic [2:0] stat_code(input logic wr, input logic io);
    case ({io, wr})
      2'b10:   stat_code = 3'b001;
      2'b11:   stat_code = 3'b010;
      2'b00:   stat_code = 3'b101;
      default: stat_code = 3'b110;
    endcase
  endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   hold_req,
  input  logic   bus_ready,
  output phase_e nxt,
  output logic   accept,
  output logic   capture
);
  phase_e cur;

  always_ff @(posedge clk) begin
    if (rst) cur <= PH_IDLE;
    else     cur <= nxt;
  end

  always_comb begin
    nxt    = cur;
    accept = 1'b0;
    case (cur)
      PH_IDLE, PH_LAST: begin
        if (hold_req) nxt = PH_HOLD;
        else if (req_valid) begin
          nxt    = PH_ADDR;
          accept = 1'b1;
        end else nxt = PH_IDLE;
      end
      PH_ADDR:        nxt = PH_DATA;
      PH_DATA:        nxt = PH_EXT;
      PH_EXT, PH_WAIT: nxt = bus_ready ? PH_LAST : PH_WAIT;
      PH_HOLD:        nxt = hold_req ? PH_HOLD : PH_IDLE;
      default:        nxt = PH_IDLE;
    endcase
  end

  assign capture = ((cur == PH_EXT) || (cur == PH_WAIT)) && bus_ready;
endmodule

// File: rtl/mbc_drv.sv
module mbc_drv
  import mbc_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int IOW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  phase_e        nxt,
  input  logic          wr,
  input  logic          io,
  input  logic          byte_acc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe,
  output logic          addr_latch,
  output logic          rd_n,
  output logic          wr_n,
  output logic [2:0]    cyc_stat,
  output logic          hi_byte_n,
  output logic          xcvr_en_n,
  output logic          dir_tx,
  output logic          ctl_oe,
  output logic          hold_ack,
  output logic          rsp_valid
);
  localparam int DPAD = AW - DW;
  localparam int IPAD = AW - IOW;

  logic [AW-1:0] data_ext;
  logic [AW-1:0] addr_ext;

  generate
    if (DPAD > 0) begin : g_dpad
      assign data_ext = {{DPAD{1'b0}}, wdata};
    end else begin : g_dnopad
      assign data_ext = wdata[AW-1:0];
    end
    if (IPAD > 0) begin : g_ipad
      assign addr_ext = io ? {{IPAD{1'b0}}, addr[IOW-1:0]} : addr;
    end else begin : g_inopad
      assign addr_ext = addr;
    end
  endgenerate

  logic in_cyc, strobe_ph;
  assign in_cyc    = (nxt == PH_ADDR) || (nxt == PH_DATA) || (nxt == PH_EXT) ||
                     (nxt == PH_WAIT) || (nxt == PH_LAST);
  assign strobe_ph = (nxt == PH_DATA) || (nxt == PH_EXT) || (nxt == PH_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_o       <= '0;
      ad_oe      <= 1'b0;
      addr_latch <= 1'b0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      cyc_stat   <= STAT_IDLE;
      hi_byte_n  <= 1'b1;
      xcvr_en_n  <= 1'b1;
      dir_tx     <= 1'b0;
      ctl_oe     <= 1'b1;
      hold_ack   <= 1'b0;
      rsp_valid  <= 1'b0;
    end else begin
      addr_latch <= (nxt == PH_ADDR);
      rd_n       <= !(strobe_ph && !wr);
      wr_n       <= !(strobe_ph && wr);
      xcvr_en_n  <= !strobe_ph;
      rsp_valid  <= (nxt == PH_LAST);
      hold_ack   <= (nxt == PH_HOLD);
      ctl_oe     <= (nxt != PH_HOLD);
      cyc_stat   <= ((nxt == PH_ADDR) || strobe_ph) ? stat_code(wr, io) : STAT_IDLE;
      hi_byte_n  <= in_cyc ? (byte_acc & ~addr[0]) : 1'b1;
      dir_tx     <= in_cyc ? wr : 1'b0;
      if (nxt == PH_ADDR) begin
        ad_o  <= addr_ext;
        ad_oe <= 1'b1;
      end else if (strobe_ph && wr) begin
        ad_o  <= data_ext;
        ad_oe <= 1'b1;
      end else begin
        ad_o  <= '0;
        ad_oe <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int IOW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic          addr_latch,
  output logic          rd_n,
  output logic          wr_n,
  output logic [2:0]    cyc_stat,
  output logic          hi_byte_n,
  output logic          xcvr_en_n,
  output logic          dir_tx,
  output logic          ctl_oe,
  input  logic          bus_ready,
  input  logic          hold_req,
  output logic          hold_ack
);
  phase_e        nxt;
  logic          accept, capture;
  logic          lat_wr, lat_io, lat_byte;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  logic          cur_wr, cur_io, cur_byte;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;

  mbc_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .hold_req(hold_req),
    .bus_ready(bus_ready), .nxt(nxt), .accept(accept), .capture(capture)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_wr <= 1'b0; lat_io <= 1'b0; lat_byte <= 1'b0;
      lat_addr <= '0; lat_wdata <= '0; rsp_rdata <= '0;
    end else begin
      if (accept) begin
        lat_wr <= req_write; lat_io <= req_io; lat_byte <= req_byte;
        lat_addr <= req_addr; lat_wdata <= req_wdata;
      end
      if (capture && !lat_wr) rsp_rdata <= ad_i;
    end
  end

  assign cur_wr    = accept ? req_write : lat_wr;
  assign cur_io    = accept ? req_io    : lat_io;
  assign cur_byte  = accept ? req_byte  : lat_byte;
  assign cur_addr  = accept ? req_addr  : lat_addr;
  assign cur_wdata = accept ? req_wdata : lat_wdata;
  assign req_ready = accept;

  mbc_drv #(.AW(AW), .DW(DW), .IOW(IOW)) u_drv (
    .clk(clk), .rst(rst), .nxt(nxt), .wr(cur_wr), .io(cur_io),
    .byte_acc(cur_byte), .addr(cur_addr), .wdata(cur_wdata),
    .ad_o(ad_o), .ad_oe(ad_oe), .addr_latch(addr_latch), .rd_n(rd_n),
    .wr_n(wr_n), .cyc_stat(cyc_stat), .hi_byte_n(hi_byte_n),
    .xcvr_en_n(xcvr_en_n), .dir_tx(dir_tx), .ctl_oe(ctl_oe),
    .hold_ack(hold_ack), .rsp_valid(rsp_valid)
  );
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic ad_oe,
  input logic addr_latch,
  input logic rd_n,
  input logic wr_n,
  input logic xcvr_en_n,
  input logic dir_tx,
  input logic ctl_oe,
  input logic hold_req,
  input logic hold_ack
);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  assert_accept_to_addr_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> addr_latch);
  assert_latch_single_R3: assert property (@(posedge clk) disable iff (rst)
    addr_latch |=> !addr_latch);
  assert_min_length_R7: assert property (@(posedge clk) disable iff (rst)
    addr_latch |=> !rsp_valid ##1 !rsp_valid);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_dir_before_en_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(xcvr_en_n) |-> $stable(dir_tx));
  assert_release_R10: assert property (@(posedge clk) disable iff (rst)
    hold_ack |-> (!ad_oe && !ctl_oe && !req_ready));
  assert_grant_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack) |-> $past(hold_req));
  assert_grant_drop_R11: assert property (@(posedge clk) disable iff (rst)
    (hold_ack && !hold_req) |=> !hold_ack);
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ad_oe(ad_oe), .addr_latch(addr_latch), .rd_n(rd_n), .wr_n(wr_n),
  .xcvr_en_n(xcvr_en_n), .dir_tx(dir_tx), .ctl_oe(ctl_oe),
  .hold_req(hold_req), .hold_ack(hold_ack)
);

// File: tb/mux_bus_ctrl_tb_top.sv
module mux_bus_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_byte = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] ad_o;
  logic        ad_oe;
  logic [15:0] ad_i = '0;
  logic        addr_latch, rd_n, wr_n, hi_byte_n, xcvr_en_n, dir_tx, ctl_oe, hold_ack;
  logic [2:0]  cyc_stat;
  logic        bus_ready = 1'b1;
  logic        hold_req = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mux_bus_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_byte(req_byte), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .addr_latch(addr_latch), .rd_n(rd_n), .wr_n(wr_n), .cyc_stat(cyc_stat),
    .hi_byte_n(hi_byte_n), .xcvr_en_n(xcvr_en_n), .dir_tx(dir_tx),
    .ctl_oe(ctl_oe), .bus_ready(bus_ready), .hold_req(hold_req),
    .hold_ack(hold_ack)
  );

  // wr, io, byte, waits[2:0], addr[19:0], wdata[15:0], rval[15:0]
  typedef struct packed {
    logic        wr;
    logic        io;
    logic        by;
    logic [2:0]  waits;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [15:0] rval;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 20'hA5432, 16'h0000, 16'h1234},
    {1'b1, 1'b0, 1'b0, 3'd0, 20'hFFFFE, 16'hBEEF, 16'h0000},
    {1'b0, 1'b1, 1'b1, 3'd2, 20'h70013, 16'h0000, 16'hC0DE},
    {1'b1, 1'b1, 1'b1, 3'd1, 20'h38000, 16'h5AA5, 16'h0000},
    {1'b0, 1'b0, 1'b1, 3'd3, 20'h00001, 16'h0000, 16'h0F0F},
    {1'b1, 1'b0, 1'b0, 3'd0, 20'h80000, 16'h7E81, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_stat(input logic wr, input logic io);
    if (io) return wr ? 3'b010 : 3'b001;
    return wr ? 3'b110 : 3'b101;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_cycle(input vec_t v, input bit hold_mid);
    logic [19:0] ea;
    logic        ebhe;
    ea   = v.io ? {4'h0, v.addr[15:0]} : v.addr;
    ebhe = v.by ? ~v.addr[0] : 1'b0;
    req_write = v.wr; req_io = v.io; req_byte = v.by;
    req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R2 accept idle", req_ready, 1);
    step();
    req_valid = 1'b0;
    chk(addr_latch == 1'b1 && ad_oe == 1'b1, "R3 latch/oe", {addr_latch, ad_oe}, 2'b11);
    chk(ad_o == ea, "R3 address", ad_o, ea);
    chk(cyc_stat == exp_stat(v.wr, v.io), "R4 status addr", cyc_stat, exp_stat(v.wr, v.io));
    chk(dir_tx == v.wr && xcvr_en_n == 1'b1, "R9 dir set, en off", {dir_tx, xcvr_en_n}, {v.wr, 1'b1});
    chk(hi_byte_n == ebhe, "R12 byte enable", hi_byte_n, ebhe);
    if (hold_mid) hold_req = 1'b1;
    bus_ready = (v.waits == 0);
    step();
    chk(rd_n == v.wr && wr_n == !v.wr, "R5 R6 strobes data", {rd_n, wr_n}, {v.wr, !v.wr});
    chk(xcvr_en_n == 1'b0, "R9 en data", xcvr_en_n, 0);
    chk(ad_oe == v.wr, "R5 R6 bus drive", ad_oe, v.wr);
    if (v.wr) chk(ad_o == {4'h0, v.wdata}, "R6 write data", ad_o, {4'h0, v.wdata});
    chk(hold_ack == 1'b0, "R10 no grant mid-cycle", hold_ack, 0);
    ad_i = v.rval;
    step();
    chk(cyc_stat == exp_stat(v.wr, v.io), "R4 status ext", cyc_stat, exp_stat(v.wr, v.io));
    chk(rsp_valid == 1'b0, "R7 no early done", rsp_valid, 0);
    for (int k = 0; k < int'(v.waits); k++) begin
      step();
      chk(rd_n == v.wr && wr_n == !v.wr && rsp_valid == 1'b0, "R7 wait state",
          {rd_n, wr_n, rsp_valid}, {v.wr, !v.wr, 1'b0});
      chk(hi_byte_n == ebhe, "R12 byte enable wait", hi_byte_n, ebhe);
      if (k == int'(v.waits) - 1) bus_ready = 1'b1;
    end
    step();
    chk(rsp_valid == 1'b1, "R7 done in last phase", rsp_valid, 1);
    chk(rd_n && wr_n && xcvr_en_n, "R9 strobes off last", {rd_n, wr_n, xcvr_en_n}, 3'b111);
    chk(cyc_stat == 3'b111, "R4 passive last", cyc_stat, 3'b111);
    if (!v.wr) chk(rsp_rdata == v.rval, "R8 read data", rsp_rdata, v.rval);
    ad_i = ~v.rval;
    if (hold_mid) chk(hold_ack == 1'b0, "R10 no grant in last", hold_ack, 0);
    step();
    if (hold_mid) begin
      chk(hold_ack == 1'b1 && ad_oe == 1'b0 && ctl_oe == 1'b0, "R10 grant after cycle",
          {hold_ack, ad_oe, ctl_oe}, 3'b100);
      hold_req = 1'b0;
      step();
      chk(hold_ack == 1'b0 && ctl_oe == 1'b1, "R11 release", {hold_ack, ctl_oe}, 2'b01);
    end else begin
      chk(rsp_valid == 1'b0 && addr_latch == 1'b0, "R8 done pulse single",
          {rsp_valid, addr_latch}, 2'b00);
      if (!v.wr) chk(rsp_rdata == v.rval, "R8 data held", rsp_rdata, v.rval);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, while reset is held
    chk(addr_latch == 0 && rd_n && wr_n && hi_byte_n && xcvr_en_n, "R1 strobes in reset",
        {addr_latch, rd_n, wr_n, hi_byte_n, xcvr_en_n}, 5'b01111);
    chk(hold_ack == 0 && ad_oe == 0 && ctl_oe == 1, "R1 drives in reset",
        {hold_ack, ad_oe, ctl_oe}, 3'b001);
    chk(cyc_stat == 3'b111, "R1 passive status", cyc_stat, 3'b111);
    rst = 1'b0;
    step();
    chk(addr_latch == 0 && rd_n && wr_n && xcvr_en_n && rsp_valid == 0, "R1 idle after reset",
        {addr_latch, rd_n, wr_n, xcvr_en_n, rsp_valid}, 5'b01110);

    for (int i = 0; i < NV; i++) do_cycle(VEC[i], 1'b0);

    // R10 hold mid-cycle, granted only after the last phase
    do_cycle(VEC[1], 1'b1);

    // R10 hold wins over a simultaneous request in idle
    hold_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h12345;
    #1 chk(req_ready == 1'b0, "R10 hold beats request", req_ready, 0);
    step();
    chk(hold_ack == 1 && ad_oe == 0 && ctl_oe == 0, "R10 grant from idle",
        {hold_ack, ad_oe, ctl_oe}, 3'b100);
    chk(req_ready == 0 && addr_latch == 0, "R10 no accept during grant",
        {req_ready, addr_latch}, 2'b00);
    step();
    chk(hold_ack == 1, "R10 grant held", hold_ack, 1);
    hold_req = 1'b0; req_valid = 1'b0;
    step();
    chk(hold_ack == 0 && ctl_oe == 1, "R11 drop one clock after release",
        {hold_ack, ctl_oe}, 2'b01);

    // R2 back-to-back: accept in last phase
    req_write = 1'b1; req_io = 1'b0; req_byte = 1'b0; req_addr = 20'h0ABCD;
    req_wdata = 16'h1111; req_valid = 1'b1; bus_ready = 1'b1;
    step();
    req_valid = 1'b0;
    step(); step(); step();
    chk(rsp_valid == 1, "R7 four-clock cycle", rsp_valid, 1);
    req_write = 1'b0; req_addr = 20'h0BEEF; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R2 accept in last phase", req_ready, 1);
    step();
    req_valid = 1'b0;
    chk(addr_latch == 1 && ad_o == 20'h0BEEF, "R2 back-to-back address",
        {addr_latch, ad_o}, {1'b1, 20'h0BEEF});
    step(); step(); step(); step();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule